// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in front of a byte-wide parallel NOR-style flash array and interprets the traffic on its byte port. Every accepted write is screened for a three-step unlock-and-command pattern. A completed pattern switches the device between three views:

- the plain array view;
- an identification view that serves a 16-bit device code;
- a boot-block view that swallows one data write.

Writes that are not part of a completed pattern are passed on to the separate page programming buffer through a forward port. When an unlock attempt breaks off, the unlock bytes it had held back are replayed ahead of the breaking write, in their original order.

The forward port carries up to three writes per cycle, one per slot. Slot 0 is the oldest. A write that the current view discards leaves its slot bit clear. The decoder therefore never stalls the bus.

Reads return one cycle later. Depending on the view, the data comes from the external array, from the identification bytes or from a fixed filler value.

A lane parameter covers three bus attachments:

- both byte lanes;
- even lane only;
- odd lane only.

A 16-bit bus access reaches this block as two byte accesses, high byte first at the even address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Reset forces the sequence tracker to idle, the view to array, and the alternate command table flag to clear. In the cycle after reset, `fwd_valid` is 0 and `rd_valid` is 0.
- R2: In array view, a plain write appears one cycle later as slot 0 (`fwd_valid`=3'b001), carrying the same data. When both lanes are attached, bit 0 of the device address is inverted. A read returns `rd_valid`=1 one cycle later, with `rd_data` equal to `arr_rd_data` for `arr_rd_addr`, which follows the same bit-0 inversion.
- R3: The sequence 0xAA to device address 0x5555, then 0x55 to 0x2AAA, then 0x90 to 0x5555 enters identification view, provided the alternate table is not armed. In that view, device offset 0 reads the high byte of ID_CODE, offset 1 reads its low byte, and every other offset reads 0xFE.
- R4: The unlock followed by 0xF0, with the primary table, returns to array view.
- R5: If the second step is wrong, two writes are forwarded in one cycle: slot 0 is 0xAA at 0x5555 and slot 1 is the current write. The tracker returns to idle.
- R6: If the third step targets an address other than 0x5555, three writes are forwarded: slot 0 is 0xAA at 0x5555, slot 1 is 0x55 at 0x2AAA, and slot 2 is the current write.
- R7: Unlock followed by 0x80 arms the alternate table until the next reset. After that, 0x60 enters identification view and 0x90 is ignored.
- R8: The alternate command 0x40 enters boot-block view, where every read returns 0xFF. The next data write is discarded and the view returns to array, so a replayed unlock loses only its first slot.
- R9: The commands 0xA0 (primary table) and 0x10/0x20 (alternate table) are consumed with no forward and no change of view.
- R10: Data writes in identification view are discarded (`fwd_valid`=0).
- R11: With single-lane attachment, a write on the wrong address parity is ignored: no forward, and the unlock progress is kept. A read on the wrong parity returns 0xFF. The device address is the bus address shifted right by one, with no bit-0 inversion.
- R12: Unlock steps and completed commands are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| bus_addr | input | BUS_AW | Byte address from the bus |
| wdata | input | 8 | Write data byte |
| arr_rd_addr | output | ARRAY_AW | Array read address (combinational) |
| arr_rd_data | input | 8 | Array data for arr_rd_addr |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Registered read data |
| fwd_valid | output | 3 | Per-slot valid of forwarded writes, slot 0 oldest |
| fwd_addr | output | 3*ARRAY_AW | Slot addresses, slot i in bits [i*ARRAY_AW +: ARRAY_AW] |
| fwd_data | output | 24 | Slot data, slot i in bits [i*8 +: 8] |

## Verification
The bench builds two instances, each with a 16-bit array and ID_CODE 0xC2A7.

The first uses both-lane attachment. With it, every command path, the replay cases and the bit-0 inversion can be observed.

The second uses even-lane-only attachment. It exposes the shifted device address and the wrong-parity filtering, including an ignored odd-lane write placed in the middle of an unlock.

A 16-bit array is needed so that the full command addresses 0x5555 and 0x2AAA survive the size masking.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;
  typedef enum logic [1:0] {VIEW_ARRAY, VIEW_IDENT, VIEW_BOOT} view_t;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_GOT_AA, SEQ_GOT_55} seq_t;
  localparam int LANE_BOTH = 0;
  localparam int LANE_EVEN = 1;
  localparam int LANE_ODD  = 2;
  localparam int NSLOT     = 3;
endpackage

// File: rtl/flash_lane_map.sv
module flash_lane_map
  import flash_dec_pkg::*;
#(
  parameter int BUS_AW    = 17,
  parameter int ARRAY_AW  = 16,
  parameter int LANE_MODE = LANE_BOTH
) (
  input  logic [BUS_AW-1:0]   bus_addr,
  output logic                lane_hit,
  output logic [ARRAY_AW-1:0] dev_addr,
  output logic [ARRAY_AW-1:0] arr_addr
);
  generate
    if (LANE_MODE == LANE_BOTH) begin : g_both
      logic unused_hi;
      assign unused_hi = ^bus_addr[BUS_AW-1:ARRAY_AW];
      assign lane_hit  = 1'b1;
      assign dev_addr  = bus_addr[ARRAY_AW-1:0];
      assign arr_addr  = {dev_addr[ARRAY_AW-1:1], ~dev_addr[0]};
    end else begin : g_single
      localparam logic ODD_SIDE = (LANE_MODE == LANE_ODD);
      assign lane_hit = (bus_addr[0] == ODD_SIDE);
      assign dev_addr = bus_addr[ARRAY_AW:1];
      assign arr_addr = dev_addr;
    end
  endgenerate
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_dec_pkg::*;
#(
  parameter int          ARRAY_AW  = 16,
  parameter int          LANE_MODE = LANE_BOTH,
  parameter logic [31:0] CMD_A1    = 32'h5555,
  parameter logic [31:0] CMD_A2    = 32'h2AAA
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_go,
  input  logic [ARRAY_AW-1:0]       dev_addr,
  input  logic [7:0]                wdata,
  output view_t                     view_q,
  output logic [NSLOT-1:0]          fwd_valid,
  output logic [NSLOT*ARRAY_AW-1:0] fwd_addr,
  output logic [NSLOT*8-1:0]        fwd_data
);
  localparam logic          INV_BIT0 = (LANE_MODE == LANE_BOTH);
  localparam [ARRAY_AW-1:0] A1 = CMD_A1[ARRAY_AW-1:0];
  localparam [ARRAY_AW-1:0] A2 = CMD_A2[ARRAY_AW-1:0];

  seq_t  seq_q, seq_n;
  logic  alt_q, alt_n;
  view_t view_n;
  logic [NSLOT-1:0]    sv, keep;
  logic [ARRAY_AW-1:0] sa [NSLOT];
  logic [7:0]          sd [NSLOT];
  logic at_a1, at_a2;

  assign at_a1 = (32'(dev_addr) == CMD_A1);
  assign at_a2 = (32'(dev_addr) == CMD_A2);

  always_comb begin
    seq_n  = seq_q;
    alt_n  = alt_q;
    view_n = view_q;
    sv     = '0;
    keep   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      sa[i] = '0;
      sd[i] = '0;
    end
    if (wr_go) begin
      case (seq_q)
        SEQ_IDLE:
          if (at_a1 && wdata == 8'hAA) seq_n = SEQ_GOT_AA;
          else begin
            sv[0] = 1'b1; sa[0] = dev_addr; sd[0] = wdata;
          end
        SEQ_GOT_AA: begin
          seq_n = SEQ_IDLE;
          if (at_a2 && wdata == 8'h55) seq_n = SEQ_GOT_55;
          else begin
            sv[1:0] = 2'b11;
            sa[0] = A1;       sd[0] = 8'hAA;
            sa[1] = dev_addr; sd[1] = wdata;
          end
        end
        SEQ_GOT_55: begin
          seq_n = SEQ_IDLE;
          if (at_a1) begin
            if (alt_q) begin
              case (wdata)
                8'h40:   view_n = VIEW_BOOT;
                8'h60:   view_n = VIEW_IDENT;
                default: ;
              endcase
            end else begin
              case (wdata)
                8'h80:   alt_n  = 1'b1;
                8'h90:   view_n = VIEW_IDENT;
                8'hF0:   view_n = VIEW_ARRAY;
                default: ;
              endcase
            end
          end else begin
            sv = 3'b111;
            sa[0] = A1;       sd[0] = 8'hAA;
            sa[1] = A2;       sd[1] = 8'h55;
            sa[2] = dev_addr; sd[2] = wdata;
          end
        end
        default: seq_n = SEQ_IDLE;
      endcase
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (sv[i]) begin
        case (view_n)
          VIEW_ARRAY: keep[i] = 1'b1;
          VIEW_BOOT:  view_n  = VIEW_ARRAY;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= SEQ_IDLE;
      alt_q     <= 1'b0;
      view_q    <= VIEW_ARRAY;
      fwd_valid <= '0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      seq_q     <= seq_n;
      alt_q     <= alt_n;
      view_q    <= view_n;
      fwd_valid <= keep;
      for (int i = 0; i < NSLOT; i++) begin
        fwd_addr[i*ARRAY_AW +: ARRAY_AW] <= {sa[i][ARRAY_AW-1:1], sa[i][0] ^ INV_BIT0};
        fwd_data[i*8 +: 8]               <= sd[i];
      end
    end
  end
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_dec_pkg::*;
#(
  parameter int          ARRAY_AW = 16,
  parameter logic [15:0] ID_CODE  = 16'hC2A7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_go,
  input  logic                lane_hit,
  input  view_t               view_q,
  input  logic [ARRAY_AW-1:0] dev_addr,
  input  logic [7:0]          arr_rd_data,
  output logic                rd_valid,
  output logic [7:0]          rd_data
);
  logic [7:0] pick;

  always_comb begin
    pick = 8'hFF;
    if (lane_hit) begin
      case (view_q)
        VIEW_ARRAY: pick = arr_rd_data;
        VIEW_IDENT:
          if (dev_addr == ARRAY_AW'(0))      pick = ID_CODE[15:8];
          else if (dev_addr == ARRAY_AW'(1)) pick = ID_CODE[7:0];
          else                               pick = 8'hFE;
        default: pick = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'hFF;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= pick;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_dec_pkg::*;
#(
  parameter int          ARRAY_AW  = 16,
  parameter int          BUS_AW    = ARRAY_AW + 1,
  parameter int          LANE_MODE = LANE_BOTH,
  parameter logic [15:0] ID_CODE   = 16'hC2A7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [BUS_AW-1:0]         bus_addr,
  input  logic [7:0]                wdata,
  output logic [ARRAY_AW-1:0]       arr_rd_addr,
  input  logic [7:0]                arr_rd_data,
  output logic                      rd_valid,
  output logic [7:0]                rd_data,
  output logic [NSLOT-1:0]          fwd_valid,
  output logic [NSLOT*ARRAY_AW-1:0] fwd_addr,
  output logic [NSLOT*8-1:0]        fwd_data
);
  logic                lane_hit;
  logic [ARRAY_AW-1:0] dev_addr;
  view_t               view_q;

  flash_lane_map #(.BUS_AW(BUS_AW), .ARRAY_AW(ARRAY_AW), .LANE_MODE(LANE_MODE)) u_map (
    .bus_addr(bus_addr), .lane_hit(lane_hit), .dev_addr(dev_addr), .arr_addr(arr_rd_addr)
  );

  flash_cmd_fsm #(.ARRAY_AW(ARRAY_AW), .LANE_MODE(LANE_MODE)) u_fsm (
    .clk(clk), .rst(rst), .wr_go(wr_en && lane_hit), .dev_addr(dev_addr), .wdata(wdata),
    .view_q(view_q), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  flash_read_mux #(.ARRAY_AW(ARRAY_AW), .ID_CODE(ID_CODE)) u_rd (
    .clk(clk), .rst(rst), .rd_go(rd_en), .lane_hit(lane_hit), .view_q(view_q),
    .dev_addr(dev_addr), .arr_rd_data(arr_rd_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int BUS_AW    = 17,
  parameter int LANE_MODE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              rd_valid,
  input logic [2:0]        fwd_valid,
  input logic [23:0]       fwd_data
);
  logic unused_rest;
  logic wrong_lane;
  assign unused_rest = ^{bus_addr[BUS_AW-1:1], fwd_data[23:16], fwd_data[7:0]};
  assign wrong_lane  = (LANE_MODE == 1) ? bus_addr[0] :
                       (LANE_MODE == 2) ? !bus_addr[0] : 1'b0;

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (fwd_valid == 3'b000 && !rd_valid)); // R1
  AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (rst) !wr_en |=> fwd_valid == 3'b000); // R2
  AST_RD_FOLLOWS:  assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R2
  AST_RD_QUIET:    assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid); // R2
  AST_REPLAY_MID:  assert property (@(posedge clk) disable iff (rst) fwd_valid[2] |-> (fwd_valid[1] && fwd_data[15:8] == 8'h55)); // R6
  AST_LANE_DROP:   assert property (@(posedge clk) disable iff (rst) (wr_en && wrong_lane) |=> fwd_valid == 3'b000); // R11
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.BUS_AW(BUS_AW), .LANE_MODE(LANE_MODE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_addr(bus_addr),
  .rd_valid(rd_valid), .fwd_valid(fwd_valid), .fwd_data(fwd_data)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_a = 1'b0, rd_a = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] arr_a_addr, arr_b_addr;
  logic [7:0]  arr_a_data, arr_b_data;
  logic        rdv_a, rdv_b;
  logic [7:0]  rdd_a, rdd_b;
  logic [2:0]  fv_a, fv_b;
  logic [47:0] fa_a, fa_b;
  logic [23:0] fd_a, fd_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign arr_a_data = arr_a_addr[7:0] ^ 8'h3C;
  assign arr_b_data = arr_b_addr[7:0] ^ 8'h3C;

  flash_cmd_decoder #(.LANE_MODE(0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_a), .rd_en(rd_a), .bus_addr(addr), .wdata(wdata),
    .arr_rd_addr(arr_a_addr), .arr_rd_data(arr_a_data), .rd_valid(rdv_a), .rd_data(rdd_a),
    .fwd_valid(fv_a), .fwd_addr(fa_a), .fwd_data(fd_a));

  flash_cmd_decoder #(.LANE_MODE(1)) uut_even (
    .clk(clk), .rst(rst), .wr_en(wr_b), .rd_en(rd_b), .bus_addr(addr), .wdata(wdata),
    .arr_rd_addr(arr_b_addr), .arr_rd_data(arr_b_data), .rd_valid(rdv_b), .rd_data(rdd_b),
    .fwd_valid(fv_b), .fwd_addr(fa_b), .fwd_data(fd_b));

  // entry: {rd, addr[17], data[8], exp_valid[3], exp[24], req[4]}
  function automatic logic [56:0] vw(input logic [16:0] a, input logic [7:0] d,
                                     input logic [2:0] v, input logic [23:0] e, input logic [3:0] r);
    return {1'b0, a, d, v, e, r};
  endfunction
  function automatic logic [56:0] vr(input logic [16:0] a, input logic [7:0] e, input logic [3:0] r);
    return {1'b1, a, 8'h00, 3'b000, 16'h0000, e, r};
  endfunction

  localparam int NV = 49;
  localparam logic [56:0] TBL [NV] = '{
    vw(17'h00010, 8'h11, 3'b001, 24'h000011, 4'd2),   // R2 plain write
    vr(17'h00010, 8'h2D, 4'd2),                       // R2 array read, bit0 inverted
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd12),       // R12
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd12),       // R12
    vw(17'h05555, 8'h90, 3'b000, 24'h0, 4'd3),        // R3 enter ident
    vr(17'h00000, 8'hC2, 4'd3),
    vr(17'h00001, 8'hA7, 4'd3),
    vr(17'h00002, 8'hFE, 4'd3),
    vw(17'h00020, 8'h33, 3'b000, 24'h0, 4'd10),       // R10 dropped
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd4),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd4),
    vw(17'h05555, 8'hF0, 3'b000, 24'h0, 4'd4),        // R4 back to array
    vr(17'h00010, 8'h2D, 4'd4),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd5),
    vw(17'h01234, 8'h77, 3'b011, 24'h0077AA, 4'd5),   // R5 replay two
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd6),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd6),
    vw(17'h00100, 8'h66, 3'b111, 24'h6655AA, 4'd6),   // R6 replay three
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd9),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd9),
    vw(17'h05555, 8'hA0, 3'b000, 24'h0, 4'd9),        // R9 primary no-op
    vr(17'h00010, 8'h2D, 4'd9),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd7),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd7),
    vw(17'h05555, 8'h80, 3'b000, 24'h0, 4'd7),        // R7 arm alternate
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd7),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd7),
    vw(17'h05555, 8'h90, 3'b000, 24'h0, 4'd7),        // R7 0x90 ignored in alt
    vr(17'h00000, 8'h3D, 4'd7),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd9),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd9),
    vw(17'h05555, 8'h10, 3'b000, 24'h0, 4'd9),        // R9 alt no-op
    vr(17'h00000, 8'h3D, 4'd9),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd7),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd7),
    vw(17'h05555, 8'h60, 3'b000, 24'h0, 4'd7),        // R7 alt ident
    vr(17'h00001, 8'hA7, 4'd7),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd8),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd8),
    vw(17'h05555, 8'h40, 3'b000, 24'h0, 4'd8),        // R8 boot view
    vr(17'h00005, 8'hFF, 4'd8),
    vw(17'h00040, 8'h99, 3'b000, 24'h0, 4'd8),        // R8 swallowed
    vr(17'h00010, 8'h2D, 4'd8),
    vw(17'h00040, 8'h99, 3'b001, 24'h000099, 4'd8),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd8),
    vw(17'h02AAA, 8'h55, 3'b000, 24'h0, 4'd8),
    vw(17'h05555, 8'h40, 3'b000, 24'h0, 4'd8),
    vw(17'h05555, 8'hAA, 3'b000, 24'h0, 4'd8),
    vw(17'h00010, 8'h12, 3'b010, 24'h001200, 4'd8)    // R8 replay loses slot 0
  };

  task automatic fail(input string req, input logic [47:0] act, input logic [47:0] exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic op(input bit on_b, input bit is_rd, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (on_b) begin wr_b = !is_rd; rd_b = is_rd; end
    else      begin wr_a = !is_rd; rd_a = is_rd; end
    @(negedge clk);
    wr_a = 0; rd_a = 0; wr_b = 0; rd_b = 0;
  endtask

  task automatic chk_fwd(input bit on_b, input string req, input logic [2:0] v, input logic [23:0] e);
    logic [2:0] av;
    logic [23:0] ad;
    av = on_b ? fv_b : fv_a;
    ad = on_b ? fd_b : fd_a;
    checks++;
    if (av != v) fail(req, {45'b0, av}, {45'b0, v});
    else for (int s = 0; s < 3; s++)
      if (v[s] && ad[s*8 +: 8] != e[s*8 +: 8]) fail(req, {24'b0, ad}, {24'b0, e});
  endtask

  task automatic chk_rd(input bit on_b, input string req, input logic [7:0] e);
    logic v;
    logic [7:0] d;
    v = on_b ? rdv_b : rdv_a;
    d = on_b ? rdd_b : rdd_a;
    checks++;
    if (!v || d != e) fail(req, {39'b0, v, d}, {39'b0, 1'b1, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (fv_a != 0 || rdv_a != 0 || fv_b != 0 || rdv_b != 0)
      fail("R1", {40'b0, fv_a, rdv_a, fv_b, rdv_b}, 48'h0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [56:0] e;
      string tag;
      e = TBL[i];
      tag = $sformatf("R%0d vec%0d", e[3:0], i);
      op(1'b0, e[56], e[55:39], e[38:31]);
      if (e[56]) chk_rd(1'b0, tag, e[11:4]);
      else       chk_fwd(1'b0, tag, e[30:28], e[27:4]);
    end

    // R6: replay addresses with bit-0 inversion
    op(1'b0, 1'b0, 17'h05555, 8'hAA);
    op(1'b0, 1'b0, 17'h02AAA, 8'h55);
    op(1'b0, 1'b0, 17'h00100, 8'h66);
    checks++;
    if (fa_a != {16'h0101, 16'h2AAB, 16'h5554}) fail("R6 addr", fa_a, {16'h0101, 16'h2AAB, 16'h5554});

    // R1: reset clears alternate flag, so 0x90 enters ident again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    checks++;
    if (fv_a != 0 || rdv_a != 0) fail("R1 re-reset", {46'b0, fv_a[0], rdv_a}, 48'h0);
    op(1'b0, 1'b0, 17'h05555, 8'hAA);
    op(1'b0, 1'b0, 17'h02AAA, 8'h55);
    op(1'b0, 1'b0, 17'h05555, 8'h90);
    op(1'b0, 1'b1, 17'h00000, 8'h00);
    chk_rd(1'b0, "R1 alt cleared", 8'hC2);

    // R11: even-lane attachment
    op(1'b1, 1'b0, 17'h00021, 8'h44);
    chk_fwd(1'b1, "R11 odd write ignored", 3'b000, 24'h0);
    op(1'b1, 1'b1, 17'h00021, 8'h00);
    chk_rd(1'b1, "R11 odd read", 8'hFF);
    op(1'b1, 1'b0, 17'h00020, 8'h44);
    chk_fwd(1'b1, "R11 even write", 3'b001, 24'h000044);
    checks++;
    if (fa_b[15:0] != 16'h0010) fail("R11 shifted addr", {32'b0, fa_b[15:0]}, 48'h0010);
    op(1'b1, 1'b1, 17'h00020, 8'h00);
    chk_rd(1'b1, "R11 even read", 8'h2C);
    op(1'b1, 1'b0, 17'h0AAAA, 8'hAA);
    op(1'b1, 1'b0, 17'h00033, 8'h01);
    op(1'b1, 1'b0, 17'h05554, 8'h55);
    op(1'b1, 1'b0, 17'h0AAAA, 8'h90);
    chk_fwd(1'b1, "R11 unlock kept", 3'b000, 24'h0);
    op(1'b1, 1'b1, 17'h00000, 8'h00);
    chk_rd(1'b1, "R11 ident hi", 8'hC2);
    op(1'b1, 1'b1, 17'h00002, 8'h00);
    chk_rd(1'b1, "R11 ident lo", 8'hA7);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule